// File: doc/BRIEF.md
# Spare Pivot Fault Collector

The collector sits beside a memory self-test engine and records every faulty cell address it reports while the test runs. Each fault is sorted on arrival. A fault whose row and column are both new to the pivot table becomes a spare pivot and takes the next free pivot slot. A fault that shares a line with an existing pivot is not kept as a full address. Only the coordinate that differs is written into a small line area owned by that pivot. A row-sharing fault writes its column, and a column-sharing fault writes its row.

Each line area is sized by the number of spares that could repair that line the other way. When an area fills, the pivot's line can only be fixed by a spare of its own direction, so it is flagged as must-repair. A pivot arriving after the table has reached its spare budget means the memory cannot be repaired, and that is flagged at once. When the memory has no row spares, only columns count: every new faulty column is a pivot and is flagged for column repair. The pivot table, line areas and flags are then handed to a later analysis stage.

Top module: `spf_collector`

## Requirements
- R1: With `num_rs` > 0, an accepted fault becomes a new pivot only when its row differs from every enabled pivot row and its column differs from every enabled pivot column. Pivots fill slots 0, 1, 2 … in arrival order, and `piv_en` is always a contiguous run of ones from bit 0.
- R2: The pivot budget is `num_rs + num_cs`, capped at MAX_RS+MAX_CS. A new pivot arriving when that many pivots are stored is not stored and sets `st_unrep`. `st_unrep` stays set until the next `start`.
- R3: A non-pivot fault whose row equals pivot i's row stores its column in row area i. One whose column equals pivot j's column stores its row in column area j. A fault matching the row of i and the column of j (i≠j) stores into both areas.
- R4: Row area i holds up to `num_cs` columns and column area j holds up to `num_rs` rows. The store that brings an area to its capacity sets `row_mr[i]` (or `col_mr[j]`), and that flag stays set until `start`.
- R5: With `num_rs` = 0, a fault is a new pivot when its column differs from every pivot column, whatever its row. Each such pivot sets `col_mr` of its slot, and no line area is written.
- R6: A fault equal to a stored pivot, or whose stored coordinate already appears in the target area, changes nothing.
- R7: A fault aimed at an area that is already at capacity is dropped. It leaves that area's entries and count unchanged and sets that area's must-repair flag.
- R8: `start` clears every table, count, flag and `st_unrep` and sets `st_state` to 1 (collecting). `st_state` encodes 0 = idle, 1 = collecting, 2 = done. `test_done` while collecting moves the state to 2. Faults are accepted only while the state is 1. In state 2 all outputs hold until the next `start`.
- R9: Every accepted fault is compared against all stored pivots in the cycle it is strobed. Its effect is visible on the outputs after the next clock edge, and a fault may be strobed on every cycle.
- R10: Pivot i occupies `piv_row[i*ROW_W +: ROW_W]` and `piv_col[i*COL_W +: COL_W]`. Entry k of row area i is `rarea_data[(i*MAX_CS+k)*COL_W +: COL_W]`, in arrival order, with its count in `rarea_cnt[i*RC_W +: RC_W]`. Column areas are laid out the same way with MAX_RS entries of ROW_W bits. Unused entries read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Synchronous start of test; clears all state |
| test_done | input | 1 | End of test pulse |
| flt_vld | input | 1 | Fault address valid strobe |
| flt_row | input | ROW_W | Faulty row address |
| flt_col | input | COL_W | Faulty column address |
| num_rs | input | CS_W of rows: $clog2(MAX_RS+1) | Row spares available |
| num_cs | input | $clog2(MAX_CS+1) | Column spares available |
| piv_en | output | P | Pivot slot valid flags |
| piv_row | output | P*ROW_W | Pivot rows |
| piv_col | output | P*COL_W | Pivot columns |
| rarea_cnt | output | P*RC_W | Row area entry counts |
| rarea_data | output | P*MAX_CS*COL_W | Row area column entries |
| carea_cnt | output | P*CC_W | Column area entry counts |
| carea_data | output | P*MAX_RS*ROW_W | Column area row entries |
| row_mr | output | P | Must-repair flag for each pivot row |
| col_mr | output | P | Must-repair flag for each pivot column |
| st_state | output | 2 | 0 idle, 1 collecting, 2 done |
| st_unrep | output | 1 | Memory found unrepairable |

## Verification
A wrong pivot decision shows up one edge after the strobe. A missed pivot leaves `piv_en` short, and a spurious one shifts every later slot. Either way, later faults land in the wrong line areas, so the error spreads to `rarea_*` and `carea_*` within a few strobes. A bad area count shows up as a must-repair flag raised one fault too early or too late, or as an entry written past the capacity. A stale clear or a missing done-hold appears at the first cycle after `start` or `test_done`. Because of this, a scoreboard snapshot of every output taken after each edge localises faults to the cycle that caused them.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } spf_state_e;

  // saturate a requested count at a structural limit
  function automatic int sat(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  // counter width able to hold 0..n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/spf_pivot_table.sv
module spf_pivot_table #(
  parameter int P     = 4,
  parameter int RW    = 3,
  parameter int CW    = 3,
  parameter int CNT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ins,
  input  logic [RW-1:0]      look_row,
  input  logic [CW-1:0]      look_col,
  output logic [P-1:0]       en,
  output logic [P*RW-1:0]    rows,
  output logic [P*CW-1:0]    cols,
  output logic [P-1:0]       row_hit,
  output logic [P-1:0]       col_hit,
  output logic [CNT_W-1:0]   cnt
);

  logic [RW-1:0] row_q [P];
  logic [CW-1:0] col_q [P];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (ins)    cnt <= cnt + CNT_W'(1);
  end

  for (genvar i = 0; i < P; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[i]    <= 1'b0;
        row_q[i] <= '0;
        col_q[i] <= '0;
      end else if (clr) begin
        en[i]    <= 1'b0;
        row_q[i] <= '0;
        col_q[i] <= '0;
      end else if (ins && cnt == CNT_W'(i)) begin
        en[i]    <= 1'b1;
        row_q[i] <= look_row;
        col_q[i] <= look_col;
      end
    end
    assign row_hit[i]          = en[i] && (row_q[i] == look_row);
    assign col_hit[i]          = en[i] && (col_q[i] == look_col);
    assign rows[i*RW +: RW]    = row_q[i];
    assign cols[i*CW +: CW]    = col_q[i];
  end

endmodule

// File: rtl/spf_line_area.sv
module spf_line_area #(
  parameter int DEPTH = 2,
  parameter int EW    = 3,
  parameter int CW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [CW-1:0]       cap,
  input  logic                wr,
  input  logic [EW-1:0]       wr_data,
  output logic [CW-1:0]       cnt,
  output logic [DEPTH*EW-1:0] data,
  output logic                mr,
  output logic                stored,
  output logic                spilled
);

  logic [EW-1:0]    ent [DEPTH];
  logic [DEPTH-1:0] match;
  logic             dup;
  logic             full;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign match[k]              = (CW'(k) < cnt) && (ent[k] == wr_data);
    assign data[k*EW +: EW]      = ent[k];
  end

  assign dup     = |match;
  assign full    = (cnt >= cap);
  assign stored  = wr && !dup && !full;
  assign spilled = wr && !dup && full;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ent[k] <= '0;
      else if (clr)                       ent[k] <= '0;
      else if (stored && cnt == CW'(k))   ent[k] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mr  <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      mr  <= 1'b0;
    end else begin
      if (stored) begin
        cnt <= cnt + CW'(1);
        if (cnt + CW'(1) == cap) mr <= 1'b1;
      end
      if (spilled) mr <= 1'b1;
    end
  end

endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       test_done,
  input  logic       over,
  output logic [1:0] state,
  output logic       unrep,
  output logic       busy
);
  import spf_pkg::*;

  spf_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      unrep <= 1'b0;
    end else if (start) begin
      st_q  <= ST_BUSY;
      unrep <= 1'b0;
    end else begin
      if (st_q == ST_BUSY && test_done) st_q <= ST_DONE;
      if (over)                         unrep <= 1'b1;
    end
  end

  assign state = st_q;
  assign busy  = (st_q == ST_BUSY);

endmodule

// File: rtl/spf_collector.sv
module spf_collector #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int MAX_RS = 3,
  parameter int MAX_CS = 3,
  localparam int P     = MAX_RS + MAX_CS,
  localparam int PC_W  = spf_pkg::cnt_w(P),
  localparam int RC_W  = spf_pkg::cnt_w(MAX_CS),
  localparam int CC_W  = spf_pkg::cnt_w(MAX_RS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       test_done,
  input  logic                       flt_vld,
  input  logic [ROW_W-1:0]           flt_row,
  input  logic [COL_W-1:0]           flt_col,
  input  logic [CC_W-1:0]            num_rs,
  input  logic [RC_W-1:0]            num_cs,
  output logic [P-1:0]               piv_en,
  output logic [P*ROW_W-1:0]         piv_row,
  output logic [P*COL_W-1:0]         piv_col,
  output logic [P*RC_W-1:0]          rarea_cnt,
  output logic [P*MAX_CS*COL_W-1:0]  rarea_data,
  output logic [P*CC_W-1:0]          carea_cnt,
  output logic [P*MAX_RS*ROW_W-1:0]  carea_data,
  output logic [P-1:0]               row_mr,
  output logic [P-1:0]               col_mr,
  output logic [1:0]                 st_state,
  output logic                       st_unrep
);
  import spf_pkg::*;

  // named internal events
  logic             busy;
  logic             accept;
  logic             col_mode;
  logic             is_new;
  logic             piv_ins;
  logic             piv_over;
  logic [P-1:0]     row_hit, col_hit;
  logic [PC_W-1:0]  piv_cnt, piv_cap;
  logic [RC_W-1:0]  cap_r;
  logic [CC_W-1:0]  cap_c;
  logic [P-1:0]     rwr, cwr;
  logic [P-1:0]     r_mr, c_mr, cm_mr;
  logic [P-1:0]     r_st, r_sp, c_st, c_sp;

  always_comb begin
    col_mode = (num_rs == '0);
    piv_cap  = PC_W'(sat(int'(num_rs) + int'(num_cs), P));
    cap_r    = RC_W'(sat(int'(num_cs), MAX_CS));
    cap_c    = CC_W'(sat(int'(num_rs), MAX_RS));
    accept   = flt_vld && busy && !start;
    is_new   = col_mode ? !(|col_hit) : (!(|row_hit) && !(|col_hit));
    piv_ins  = accept && is_new && (piv_cnt < piv_cap);
    piv_over = accept && is_new && (piv_cnt >= piv_cap);
    for (int i = 0; i < P; i++) begin
      rwr[i] = accept && !col_mode && row_hit[i] && !col_hit[i];
      cwr[i] = accept && !col_mode && col_hit[i] && !row_hit[i];
    end
  end

  spf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .test_done (test_done),
    .over      (piv_over),
    .state     (st_state),
    .unrep     (st_unrep),
    .busy      (busy)
  );

  spf_pivot_table #(.P(P), .RW(ROW_W), .CW(COL_W), .CNT_W(PC_W)) u_piv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start),
    .ins      (piv_ins),
    .look_row (flt_row),
    .look_col (flt_col),
    .en       (piv_en),
    .rows     (piv_row),
    .cols     (piv_col),
    .row_hit  (row_hit),
    .col_hit  (col_hit),
    .cnt      (piv_cnt)
  );

  for (genvar i = 0; i < P; i++) begin : g_area
    spf_line_area #(.DEPTH(MAX_CS), .EW(COL_W), .CW(RC_W)) u_rarea (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .cap     (cap_r),
      .wr      (rwr[i]),
      .wr_data (flt_col),
      .cnt     (rarea_cnt[i*RC_W +: RC_W]),
      .data    (rarea_data[i*MAX_CS*COL_W +: MAX_CS*COL_W]),
      .mr      (r_mr[i]),
      .stored  (r_st[i]),
      .spilled (r_sp[i])
    );

    spf_line_area #(.DEPTH(MAX_RS), .EW(ROW_W), .CW(CC_W)) u_carea (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .cap     (cap_c),
      .wr      (cwr[i]),
      .wr_data (flt_row),
      .cnt     (carea_cnt[i*CC_W +: CC_W]),
      .data    (carea_data[i*MAX_RS*ROW_W +: MAX_RS*ROW_W]),
      .mr      (c_mr[i]),
      .stored  (c_st[i]),
      .spilled (c_sp[i])
    );

    // column-only mode: each new pivot column is a column repair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          cm_mr[i] <= 1'b0;
      else if (start)                                      cm_mr[i] <= 1'b0;
      else if (piv_ins && col_mode && piv_cnt == PC_W'(i)) cm_mr[i] <= 1'b1;
    end
  end

  assign row_mr = r_mr;
  assign col_mr = c_mr | cm_mr;

endmodule

// File: rtl/spf_collector_chk.sv
module spf_collector_chk #(
  parameter int P = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [P-1:0] piv_en,
  input logic [P-1:0] row_mr,
  input logic [P-1:0] col_mr,
  input logic [1:0]   st_state,
  input logic         st_unrep
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (piv_en == '0 && row_mr == '0 && col_mr == '0 && !st_unrep && st_state == 2'd1)); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_state == 2'd2 && !start) |=> (st_state == 2'd2 && $stable(piv_en) && $stable(row_mr)
                                      && $stable(col_mr) && $stable(st_unrep))); // R8

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_state == 2'd0) |-> (piv_en == '0)); // R8

  AST_PIV_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (piv_en & (piv_en + P'(1))) == '0); // R1

  AST_PIV_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($countones(piv_en) <= $countones($past(piv_en)) + 1)); // R9

  AST_UNREP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_unrep && !start) |=> st_unrep); // R2

  AST_MR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (((row_mr & $past(row_mr)) == $past(row_mr)) && ((col_mr & $past(col_mr)) == $past(col_mr)))); // R4

endmodule

bind spf_collector spf_collector_chk #(.P(P)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .piv_en   (piv_en),
  .row_mr   (row_mr),
  .col_mr   (col_mr),
  .st_state (st_state),
  .st_unrep (st_unrep)
);

// File: tb/spf_collector_bench.sv
`timescale 1ns/1ps
module spf_collector_bench;

  localparam int ROW_W  = 3;
  localparam int COL_W  = 3;
  localparam int MAX_RS = 3;
  localparam int MAX_CS = 3;
  localparam int P      = MAX_RS + MAX_CS;
  localparam int RC_W   = $clog2(MAX_CS + 1);
  localparam int CC_W   = $clog2(MAX_RS + 1);
  localparam int TOT    = P + P*ROW_W + P*COL_W + P*RC_W + P*MAX_CS*COL_W
                        + P*CC_W + P*MAX_RS*ROW_W + 2*P + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, test_done = 1'b0, flt_vld = 1'b0;
  logic [ROW_W-1:0] flt_row = '0;
  logic [COL_W-1:0] flt_col = '0;
  logic [CC_W-1:0]  num_rs = '0;
  logic [RC_W-1:0]  num_cs = '0;
  logic [P-1:0]               piv_en, row_mr, col_mr;
  logic [P*ROW_W-1:0]         piv_row;
  logic [P*COL_W-1:0]         piv_col;
  logic [P*RC_W-1:0]          rarea_cnt;
  logic [P*MAX_CS*COL_W-1:0]  rarea_data;
  logic [P*CC_W-1:0]          carea_cnt;
  logic [P*MAX_RS*ROW_W-1:0]  carea_data;
  logic [1:0]                 st_state;
  logic                       st_unrep;

  always #4 clk = ~clk;

  spf_collector #(.ROW_W(ROW_W), .COL_W(COL_W), .MAX_RS(MAX_RS), .MAX_CS(MAX_CS)) u_spf_collector (
    .clk(clk), .rst_n(rst_n), .start(start), .test_done(test_done),
    .flt_vld(flt_vld), .flt_row(flt_row), .flt_col(flt_col),
    .num_rs(num_rs), .num_cs(num_cs),
    .piv_en(piv_en), .piv_row(piv_row), .piv_col(piv_col),
    .rarea_cnt(rarea_cnt), .rarea_data(rarea_data),
    .carea_cnt(carea_cnt), .carea_data(carea_data),
    .row_mr(row_mr), .col_mr(col_mr), .st_state(st_state), .st_unrep(st_unrep)
  );

  // ---------------- reference model ----------------
  logic             m_en  [P];
  logic [ROW_W-1:0] m_pr  [P];
  logic [COL_W-1:0] m_pc  [P];
  int               m_rc  [P];
  int               m_cc  [P];
  logic [COL_W-1:0] m_rd  [P][MAX_CS];
  logic [ROW_W-1:0] m_cd  [P][MAX_RS];
  logic             m_rmr [P];
  logic             m_cmr [P];
  int               m_st;
  logic             m_un;
  int               m_np;

  task automatic model_clear();
    for (int i = 0; i < P; i++) begin
      m_en[i] = 0; m_pr[i] = '0; m_pc[i] = '0; m_rc[i] = 0; m_cc[i] = 0;
      m_rmr[i] = 0; m_cmr[i] = 0;
      for (int k = 0; k < MAX_CS; k++) m_rd[i][k] = '0;
      for (int k = 0; k < MAX_RS; k++) m_cd[i][k] = '0;
    end
    m_un = 0; m_np = 0;
  endtask

  task automatic model_step(input bit v, input int r, input int c,
                            input bit s, input bit d, input int rs, input int cs);
    int rh, ch, budget, rcap, ccap;
    bit seen;
    if (s) begin
      model_clear();
      m_st = 1;
      return;
    end
    if (v && m_st == 1) begin
      rh = -1; ch = -1;
      for (int i = 0; i < P; i++) begin
        if (m_en[i] && int'(m_pr[i]) == r) rh = i;
        if (m_en[i] && int'(m_pc[i]) == c) ch = i;
      end
      budget = (rs + cs > P) ? P : rs + cs;
      rcap   = (cs > MAX_CS) ? MAX_CS : cs;
      ccap   = (rs > MAX_RS) ? MAX_RS : rs;
      if ((rs == 0 && ch < 0) || (rs != 0 && rh < 0 && ch < 0)) begin
        if (m_np < budget) begin
          m_en[m_np] = 1; m_pr[m_np] = ROW_W'(r); m_pc[m_np] = COL_W'(c);
          if (rs == 0) m_cmr[m_np] = 1;
          m_np++;
        end else m_un = 1;
      end else if (rs != 0 && rh != ch) begin
        if (rh >= 0) begin
          seen = 0;
          for (int k = 0; k < m_rc[rh]; k++) if (int'(m_rd[rh][k]) == c) seen = 1;
          if (!seen) begin
            if (m_rc[rh] >= rcap) m_rmr[rh] = 1;
            else begin
              m_rd[rh][m_rc[rh]] = COL_W'(c); m_rc[rh]++;
              if (m_rc[rh] == rcap) m_rmr[rh] = 1;
            end
          end
        end
        if (ch >= 0) begin
          seen = 0;
          for (int k = 0; k < m_cc[ch]; k++) if (int'(m_cd[ch][k]) == r) seen = 1;
          if (!seen) begin
            if (m_cc[ch] >= ccap) m_cmr[ch] = 1;
            else begin
              m_cd[ch][m_cc[ch]] = ROW_W'(r); m_cc[ch]++;
              if (m_cc[ch] == ccap) m_cmr[ch] = 1;
            end
          end
        end
      end
    end
    if (d && m_st == 1) m_st = 2;
  endtask

  function automatic logic [TOT-1:0] snap_model();
    logic [P-1:0] en, rm, cm;
    logic [P*ROW_W-1:0] pr;
    logic [P*COL_W-1:0] pc;
    logic [P*RC_W-1:0] rc;
    logic [P*MAX_CS*COL_W-1:0] rd;
    logic [P*CC_W-1:0] cc;
    logic [P*MAX_RS*ROW_W-1:0] cd;
    for (int i = 0; i < P; i++) begin
      en[i] = m_en[i]; rm[i] = m_rmr[i]; cm[i] = m_cmr[i];
      pr[i*ROW_W +: ROW_W] = m_pr[i];
      pc[i*COL_W +: COL_W] = m_pc[i];
      rc[i*RC_W +: RC_W]   = RC_W'(m_rc[i]);
      cc[i*CC_W +: CC_W]   = CC_W'(m_cc[i]);
      for (int k = 0; k < MAX_CS; k++) rd[(i*MAX_CS+k)*COL_W +: COL_W] = m_rd[i][k];
      for (int k = 0; k < MAX_RS; k++) cd[(i*MAX_RS+k)*ROW_W +: ROW_W] = m_cd[i][k];
    end
    return {en, pr, pc, rc, rd, cc, cd, rm, cm, 2'(m_st), m_un};
  endfunction

  // ---------------- scoreboard ----------------
  logic [TOT-1:0] q_v[$];
  int             q_due[$];
  string          q_tag[$];
  int cyc = 0;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic drive(input bit v, input int r, input int c, input bit s, input bit d,
                       input int rs, input int cs, input string tag);
    @(negedge clk);
    flt_vld = v; flt_row = ROW_W'(r); flt_col = COL_W'(c);
    start = s; test_done = d; num_rs = CC_W'(rs); num_cs = RC_W'(cs);
    model_step(v, r, c, s, d, rs, cs);
    q_v.push_back(snap_model());
    q_due.push_back(cyc + 1);
    q_tag.push_back(tag);
  endtask

  initial begin : monitor
    logic [TOT-1:0] act, exp_v;
    string t;
    forever begin
      @(negedge clk);
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
        exp_v = q_v.pop_front();
        void'(q_due.pop_front());
        t = q_tag.pop_front();
        act = {piv_en, piv_row, piv_col, rarea_cnt, rarea_data, carea_cnt, carea_data,
               row_mr, col_mr, st_state, st_unrep};
        n_vec++;
        if (act !== exp_v) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, act, exp_v);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    model_clear();
    m_st = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // reset state; fault while idle is ignored (R8)
    drive(0, 0, 0, 0, 0, 2, 2, "R8 reset state");
    drive(1, 3, 3, 0, 0, 2, 2, "R8 idle fault ignored");
    drive(0, 0, 0, 1, 0, 2, 2, "R8 start");
    // worked sequence, back to back (R1 R3 R4 R9 R10)
    drive(1, 2, 1, 0, 0, 2, 2, "R1 first pivot");
    drive(1, 5, 3, 0, 0, 2, 2, "R1 second pivot");
    drive(1, 5, 1, 0, 0, 2, 2, "R3 both areas");
    drive(1, 2, 3, 0, 0, 2, 2, "R3 both areas second");
    drive(1, 1, 4, 0, 0, 2, 2, "R9 back to back pivot");
    drive(1, 7, 7, 0, 0, 2, 2, "R10 fourth slot");
    drive(1, 7, 4, 0, 0, 2, 2, "R3 cross");
    drive(1, 5, 7, 0, 0, 2, 2, "R4 row 5 must repair");
    drive(1, 2, 1, 0, 0, 2, 2, "R6 repeat pivot");
    drive(1, 5, 1, 0, 0, 2, 2, "R6 repeat area entry");
    drive(1, 5, 0, 0, 0, 2, 2, "R7 full area drop");
    drive(1, 0, 0, 0, 0, 2, 2, "R2 budget exceeded");
    drive(1, 3, 5, 0, 0, 2, 2, "R2 still unrepairable");
    drive(0, 0, 0, 0, 1, 2, 2, "R8 test done");
    drive(1, 3, 2, 0, 0, 2, 2, "R8 done holds");
    // column-only mode (R5)
    drive(0, 0, 0, 1, 0, 0, 3, "R8 restart clears");
    drive(1, 1, 2, 0, 0, 0, 3, "R5 column pivot");
    drive(1, 4, 2, 0, 0, 0, 3, "R5 same column");
    drive(1, 1, 5, 0, 0, 0, 3, "R5 same row new column");
    drive(1, 6, 6, 0, 0, 0, 3, "R5 third column");
    drive(1, 0, 0, 0, 0, 0, 3, "R5 R2 column budget exceeded");
    // single spares, capacity one (R4 R7)
    drive(0, 0, 0, 1, 0, 1, 1, "R8 restart");
    drive(1, 1, 1, 0, 0, 1, 1, "R1 pivot");
    drive(1, 1, 2, 0, 0, 1, 1, "R4 row area cap one");
    drive(1, 3, 1, 0, 0, 1, 1, "R4 column area cap one");
    drive(1, 1, 6, 0, 0, 1, 1, "R7 drop at full row area");
    drive(1, 4, 4, 0, 0, 1, 1, "R1 second pivot");
    drive(1, 4, 2, 0, 0, 1, 1, "R3 row share only");
    drive(0, 0, 0, 0, 0, 1, 1, "R9 idle settle");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule